// File: doc/BRIEF.md
# Per-Crossing Multi-Hit Encoder

This block sits at the edge of a long-pixel sensor array. The array is organised as a set of virtual strips, and every strip holds a row of pixels along its length. The comparators deliver one flag per pixel. At every rising edge of the crossing clock the block takes a snapshot of all flags. It picks at most a fixed number of fired pixels from the snapshot and turns each one into a hit word. A hit word holds the strip number and the binary position of the pixel along that strip.

The hit words leave on a link clock that runs eight times faster than the crossing clock. Each crossing therefore gets a frame of eight slots. Every frame is emitted, even when it is empty, and there is no flow control. Each snapshot reaches the link after the same fixed latency. A receiver finds frame boundaries from a marker lane and learns from a sideband flag that hits were dropped. Both clocks come from one source and share rising edges at crossing boundaries.

Top module: `hitenc_top`

## Requirements
- R1: The flat flag index is strip*32 + pixel. A hit word carries the strip in lane_data[11:5] and the pixel position in lane_data[4:0], so the word equals the flat index of the pixel.
- R2: When more flags are set than there are slots, the lowest flat indices win: the lowest strip first, then the lowest pixel within that strip.
- R3: Slots carry hits in ascending flat-index order, starting in the first slot with no gaps. A slot without a hit shows lane_valid = 0 and lane_data = 0.
- R4: frame_ovf is 1 for all eight slots of a frame whose snapshot had more than eight flags set. It is 0 when eight or fewer flags were set, including exactly eight.
- R5: frame_mark is 1 in the first slot of each frame only. Once the link has aligned after reset, markers are exactly eight link cycles apart.
- R6: The flags sampled at crossing edge n form the frame whose first slot is driven from crossing edge n+2 until the next link edge.
- R7: A new, independent snapshot is taken at every crossing edge. Back-to-back crossings with different patterns each produce their own frame.
- R8: A synchronous active-high reset clears every stage. While reset is held, all outputs are 0. After release, frames carry no valid hit and no overflow until the first sampled snapshot arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bx_clk | input | 1 | Crossing clock; flags are sampled on its rising edge |
| lk_clk | input | 1 | Link clock, eight times bx_clk, edge-aligned with it |
| rst | input | 1 | Synchronous active-high reset for both domains |
| pix_hit | input | 4096 | Comparator flags, index strip*32 + pixel |
| lane_data | output | 12 | Hit word of the current slot: {strip, pixel} |
| lane_valid | output | 1 | Current slot carries a hit |
| frame_mark | output | 1 | High in the first slot of each frame |
| frame_ovf | output | 1 | More than eight hits in this frame's snapshot |

## Verification
The scoreboard records the crossing edge at which each pattern is sampled. It expects that pattern's frame exactly two crossing edges later. A design that is off by a crossing shows up as a missing frame, or as a pattern compared against a neighbouring crossing. The bench covers four corner cases:
- Exactly eight hits against nine hits. A wrong comparison in the overflow logic would raise the flag one hit early or one hit late.
- A full strip and a fully set array. A design that ranks only within strips, or that drops the saturation of its counters, would pick the wrong eight pixels or wrap the overflow.
- Single hits at the first and last pixel of the array. These expose a swapped or truncated strip and pixel field.
- A pattern whose flags are set out of address order. This catches a selection scan that does not return the lowest addresses first.

// File: rtl/hitenc_pkg.sv
package hitenc_pkg;
  localparam int unsigned DEF_STRIPS   = 128;
  localparam int unsigned DEF_PIX      = 32;
  localparam int unsigned DEF_MAX_HITS = 8;
endpackage

// File: rtl/hitenc_strip_scan.sv
module hitenc_strip_scan #(
  parameter int unsigned NPIX = hitenc_pkg::DEF_PIX,
  parameter int unsigned MAXH = hitenc_pkg::DEF_MAX_HITS
) (
  input  logic [NPIX-1:0]                        flags,
  output logic [$clog2(MAXH+2)-1:0]              cnt,
  output logic [MAXH-1:0][$clog2(NPIX)-1:0]      idx
);
  localparam int unsigned PW  = $clog2(NPIX);
  localparam int unsigned CW  = $clog2(MAXH + 2);
  localparam int unsigned SLW = $clog2(MAXH);
  localparam logic [CW-1:0] MAXH_C = CW'(MAXH);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  // Walk the strip from pixel 0 upward, keep the first MAXH positions,
  // count hits saturating at MAXH+1 so overflow survives.
  always_comb begin
    logic [CW-1:0] c;
    c   = '0;
    idx = '0;
    for (int p = 0; p < NPIX; p++) begin
      if (flags[p]) begin
        if (c < MAXH_C) idx[c[SLW-1:0]] = PW'(p);
        if (c <= MAXH_C) c = c + ONE_C;
      end
    end
    cnt = c;
  end
endmodule

// File: rtl/hitenc_merge.sv
module hitenc_merge #(
  parameter int unsigned NS   = hitenc_pkg::DEF_STRIPS,
  parameter int unsigned NPIX = hitenc_pkg::DEF_PIX,
  parameter int unsigned MAXH = hitenc_pkg::DEF_MAX_HITS
) (
  input  logic [NS-1:0][$clog2(MAXH+2)-1:0]              cnt,
  input  logic [NS-1:0][MAXH-1:0][$clog2(NPIX)-1:0]      idx,
  output logic [MAXH-1:0]                                vld,
  output logic [MAXH-1:0][$clog2(NS)+$clog2(NPIX)-1:0]   word,
  output logic                                           ovf
);
  localparam int unsigned SW  = $clog2(NS);
  localparam int unsigned CW  = $clog2(MAXH + 2);
  localparam int unsigned SLW = $clog2(MAXH);
  localparam logic [CW-1:0] MAXH_C = CW'(MAXH);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  // Strips are visited in ascending order; each strip's local list is
  // already sorted, so appending gives global ascending address order.
  always_comb begin
    logic [CW-1:0] tot;
    tot  = '0;
    vld  = '0;
    word = '0;
    ovf  = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (cnt[s] > MAXH_C) ovf = 1'b1;
      for (int j = 0; j < MAXH; j++) begin
        if (CW'(j) < cnt[s]) begin
          if (tot < MAXH_C) begin
            vld[tot[SLW-1:0]]  = 1'b1;
            word[tot[SLW-1:0]] = {SW'(s), idx[s][j]};
            tot = tot + ONE_C;
          end else begin
            ovf = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hitenc_serializer.sv
module hitenc_serializer #(
  parameter int unsigned MAXH = hitenc_pkg::DEF_MAX_HITS,
  parameter int unsigned WW   = 12
) (
  input  logic                      lk_clk,
  input  logic                      rst,
  input  logic                      bx_tog,
  input  logic [MAXH-1:0]           fr_vld,
  input  logic [MAXH-1:0][WW-1:0]   fr_word,
  input  logic                      fr_ovf,
  output logic [WW-1:0]             lane_data,
  output logic                      lane_valid,
  output logic                      frame_mark,
  output logic                      frame_ovf
);
  localparam int unsigned SLW = $clog2(MAXH);
  localparam logic [SLW-1:0] ONE_P = SLW'(1);

  logic [SLW-1:0]          ph;
  logic [SLW-1:0]          ph_n;
  logic                    tog_seen;
  logic [MAXH-1:0]         hold_vld;
  logic [MAXH-1:0][WW-1:0] hold_word;

  // A toggle change is seen one link cycle after a crossing edge:
  // that cycle is slot 1, which re-anchors the free-running phase.
  always_comb ph_n = (tog_seen != bx_tog) ? ONE_P : ph + ONE_P;

  always_ff @(posedge lk_clk) begin
    if (rst) begin
      ph         <= '1;
      tog_seen   <= 1'b0;
      hold_vld   <= '0;
      hold_word  <= '0;
      lane_data  <= '0;
      lane_valid <= 1'b0;
      frame_mark <= 1'b0;
      frame_ovf  <= 1'b0;
    end else begin
      tog_seen <= bx_tog;
      ph       <= ph_n;
      if (ph_n == '0) begin
        hold_vld   <= fr_vld;
        hold_word  <= fr_word;
        frame_ovf  <= fr_ovf;
        lane_valid <= fr_vld[0];
        lane_data  <= fr_word[0];
        frame_mark <= 1'b1;
      end else begin
        lane_valid <= hold_vld[ph_n];
        lane_data  <= hold_word[ph_n];
        frame_mark <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hitenc_top.sv
module hitenc_top #(
  parameter int unsigned N_STRIPS      = hitenc_pkg::DEF_STRIPS,
  parameter int unsigned PIX_PER_STRIP = hitenc_pkg::DEF_PIX,
  parameter int unsigned MAX_HITS      = hitenc_pkg::DEF_MAX_HITS
) (
  input  logic                                           bx_clk,
  input  logic                                           lk_clk,
  input  logic                                           rst,
  input  logic [N_STRIPS*PIX_PER_STRIP-1:0]              pix_hit,
  output logic [$clog2(N_STRIPS)+$clog2(PIX_PER_STRIP)-1:0] lane_data,
  output logic                                           lane_valid,
  output logic                                           frame_mark,
  output logic                                           frame_ovf
);
  localparam int unsigned NF = N_STRIPS * PIX_PER_STRIP;
  localparam int unsigned PW = $clog2(PIX_PER_STRIP);
  localparam int unsigned WW = $clog2(N_STRIPS) + PW;
  localparam int unsigned CW = $clog2(MAX_HITS + 2);

  logic [NF-1:0]                              flag_q;
  logic [N_STRIPS-1:0][CW-1:0]                s_cnt;
  logic [N_STRIPS-1:0][MAX_HITS-1:0][PW-1:0]  s_idx;
  logic [MAX_HITS-1:0]                        m_vld;
  logic [MAX_HITS-1:0][WW-1:0]                m_word;
  logic                                       m_ovf;
  logic [MAX_HITS-1:0]                        fr_vld;
  logic [MAX_HITS-1:0][WW-1:0]                fr_word;
  logic                                       fr_ovf;
  logic                                       bx_tog;

  generate
    for (genvar s = 0; s < N_STRIPS; s++) begin : g_strip
      hitenc_strip_scan #(.NPIX(PIX_PER_STRIP), .MAXH(MAX_HITS)) u_scan (
        .flags (flag_q[s*PIX_PER_STRIP +: PIX_PER_STRIP]),
        .cnt   (s_cnt[s]),
        .idx   (s_idx[s])
      );
    end
  endgenerate

  hitenc_merge #(.NS(N_STRIPS), .NPIX(PIX_PER_STRIP), .MAXH(MAX_HITS)) u_merge (
    .cnt  (s_cnt),
    .idx  (s_idx),
    .vld  (m_vld),
    .word (m_word),
    .ovf  (m_ovf)
  );

  // Crossing domain: edge n samples flags, edge n+1 latches the encoded frame.
  always_ff @(posedge bx_clk) begin
    if (rst) begin
      flag_q  <= '0;
      fr_vld  <= '0;
      fr_word <= '0;
      fr_ovf  <= 1'b0;
      bx_tog  <= 1'b0;
    end else begin
      flag_q  <= pix_hit;
      fr_vld  <= m_vld;
      fr_word <= m_word;
      fr_ovf  <= m_ovf;
      bx_tog  <= ~bx_tog;
    end
  end

  // Link domain: edge n+2 starts shifting the frame out.
  hitenc_serializer #(.MAXH(MAX_HITS), .WW(WW)) u_ser (
    .lk_clk     (lk_clk),
    .rst        (rst),
    .bx_tog     (bx_tog),
    .fr_vld     (fr_vld),
    .fr_word    (fr_word),
    .fr_ovf     (fr_ovf),
    .lane_data  (lane_data),
    .lane_valid (lane_valid),
    .frame_mark (frame_mark),
    .frame_ovf  (frame_ovf)
  );
endmodule

// File: rtl/hitenc_chk.sv
module hitenc_chk #(
  parameter int unsigned WW = 12
) (
  input logic          lk_clk,
  input logic          rst,
  input logic [WW-1:0] lane_data,
  input logic          lane_valid,
  input logic          frame_mark,
  input logic          frame_ovf
);
  assert_mark_single_R5: assert property (@(posedge lk_clk) disable iff (rst)
    frame_mark |=> !frame_mark);

  assert_empty_zero_R3: assert property (@(posedge lk_clk) disable iff (rst)
    !lane_valid |-> (lane_data == '0));

  assert_packed_R3: assert property (@(posedge lk_clk) disable iff (rst)
    (!frame_mark && lane_valid) |-> $past(lane_valid));

  assert_ascending_R2: assert property (@(posedge lk_clk) disable iff (rst)
    (!frame_mark && lane_valid) |-> (lane_data > $past(lane_data)));

  assert_ovf_held_R4: assert property (@(posedge lk_clk) disable iff (rst)
    !frame_mark |-> $stable(frame_ovf));

  assert_ovf_full_R4: assert property (@(posedge lk_clk) disable iff (rst)
    (frame_mark && frame_ovf) |-> lane_valid);

  assert_reset_clear_R8: assert property (@(posedge lk_clk)
    rst |=> (!lane_valid && !frame_ovf && !frame_mark));
endmodule

bind hitenc_top hitenc_chk #(.WW(WW)) chk_i (
  .lk_clk     (lk_clk),
  .rst        (rst),
  .lane_data  (lane_data),
  .lane_valid (lane_valid),
  .frame_mark (frame_mark),
  .frame_ovf  (frame_ovf)
);

// File: tb/hitenc_top_tb_top.sv
module hitenc_top_tb_top;
  localparam int NS = 128;
  localparam int NP = 32;
  localparam int MH = 8;
  localparam int NF = NS * NP;
  localparam int WW = 12;

  typedef struct packed {
    int                    due;
    logic                  ovf;
    logic [MH-1:0]         vld;
    logic [MH-1:0][WW-1:0] w;
  } exp_t;

  logic          bx_clk = 1'b0;
  logic          lk_clk = 1'b0;
  logic          rst = 1'b1;
  logic [NF-1:0] pix_hit = '0;
  logic [WW-1:0] lane_data;
  logic          lane_valid, frame_mark, frame_ovf;

  int total = 0;
  int bad = 0;
  int bx_cnt = 0;
  exp_t  expq[$];
  string tagq[$];

  hitenc_top dut_i (
    .bx_clk(bx_clk), .lk_clk(lk_clk), .rst(rst), .pix_hit(pix_hit),
    .lane_data(lane_data), .lane_valid(lane_valid),
    .frame_mark(frame_mark), .frame_ovf(frame_ovf)
  );

  // 50 MHz link clock, crossing clock at one eighth, rising edges shared.
  initial begin
    forever begin
      for (int i = 0; i < 8; i++) begin
        #10;
        lk_clk = 1'b1;
        if (i == 0) bx_clk = 1'b1;
        if (i == 4) bx_clk = 1'b0;
        #10;
        lk_clk = 1'b0;
      end
    end
  end

  always @(posedge bx_clk) bx_cnt <= bx_cnt + 1;

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Driver: hold one pattern across one sampling edge and push its expectation.
  task automatic drive(input logic [NF-1:0] pat, input string tag);
    exp_t e;
    int   n;
    @(negedge bx_clk);
    @(negedge lk_clk);
    pix_hit = pat;
    e = '0;
    n = 0;
    for (int f = 0; f < NF; f++) begin
      if (pat[f]) begin
        if (n < MH) begin
          e.vld[n] = 1'b1;
          e.w[n]   = WW'(f);
        end
        n++;
      end
    end
    e.ovf = (n > MH);
    e.due = bx_cnt + 3;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  // Monitor: collect eight slots from each marker and compare.
  int slot = -1;
  int marks = 0;
  int gap = 0;
  int got_c = 0;
  logic got_ovf;
  logic [MH-1:0] got_v;
  logic [MH-1:0][WW-1:0] got_w;

  task automatic frame_done();
    exp_t  e;
    string t;
    while (expq.size() > 0 && expq[0].due < got_c) begin
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(1'b0, $sformatf("R6 %s frame due at edge %0d not seen, now edge %0d", t, e.due, got_c));
    end
    if (expq.size() > 0 && expq[0].due == got_c) begin
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(got_v == e.vld && got_w == e.w && got_ovf == e.ovf,
          $sformatf("%s/R6 edge %0d: got v=%b w=%h ovf=%b exp v=%b w=%h ovf=%b",
                    t, got_c, got_v, got_w, got_ovf, e.vld, e.w, e.ovf));
    end else begin
      chk(got_v == '0 && got_w == '0 && !got_ovf,
          $sformatf("R8 idle frame edge %0d: got v=%b w=%h ovf=%b exp all zero",
                    got_c, got_v, got_w, got_ovf));
    end
  endtask

  always @(negedge lk_clk) begin
    if (rst) begin
      slot  = -1;
      marks = 0;
      gap   = 0;
    end else begin
      gap++;
      if (frame_mark) begin
        if (marks >= 3)
          chk(gap == 8, $sformatf("R5 marker spacing got %0d exp 8", gap));
        gap     = 0;
        marks++;
        slot    = 0;
        got_c   = bx_cnt;
        got_ovf = frame_ovf;
      end else if (slot >= 0 && frame_ovf != got_ovf) begin
        chk(1'b0, $sformatf("R4 overflow changed in frame: got %b exp %b", frame_ovf, got_ovf));
      end
      if (slot >= 0) begin
        got_v[slot] = lane_valid;
        got_w[slot] = lane_data;
        slot++;
        if (slot == MH) begin
          frame_done();
          slot = -1;
        end
      end
    end
  end

  // Watchdog.
  initial begin
    #2_000_000;
    chk(1'b0, "R6 watchdog expired: got hung run exp completion");
    summary();
  end

  initial begin
    logic [NF-1:0] p;
    void'($urandom(7));
    repeat (30) @(negedge lk_clk);
    chk(lane_valid == 1'b0 && lane_data == '0 && frame_ovf == 1'b0 && frame_mark == 1'b0,
        $sformatf("R8 reset outputs got v=%b d=%h o=%b m=%b exp 0", lane_valid, lane_data,
                  frame_ovf, frame_mark));
    rst = 1'b0;
    repeat (40) @(negedge lk_clk);

    drive('0, "R3");
    p = '0; p[0] = 1'b1;                 drive(p, "R1");
    p = '0; p[NF-1] = 1'b1;              drive(p, "R1");
    p = '0; p[5*NP+17] = 1'b1;           drive(p, "R1");
    p = '0;
    for (int k = 0; k < 8; k++) p[k*500 + 3] = 1'b1;
    drive(p, "R4");
    p = '0;
    for (int k = 0; k < 9; k++) p[k*450 + 1] = 1'b1;
    drive(p, "R4");
    p = '0; p[9*NP +: NP] = '1;           drive(p, "R2");
    drive('1, "R2");
    p = '0; p[3*NP+30] = 1'b1; p[2*NP+1] = 1'b1; p[3*NP] = 1'b1; p[100*NP+4] = 1'b1;
    drive(p, "R2");
    p = '0; p[40] = 1'b1; p[41] = 1'b1;  drive(p, "R3");
    for (int r = 0; r < 40; r++) begin
      int n;
      p = '0;
      n = $urandom_range(0, 12);
      for (int k = 0; k < n; k++) p[$urandom_range(0, NF-1)] = 1'b1;
      drive(p, "R7");
    end
    drive('0, "R7");
    repeat (40) @(negedge lk_clk);
    chk(expq.size() == 0, $sformatf("R6 pending frames got %0d exp 0", expq.size()));
    summary();
  end
endmodule